// File: doc/BRIEF.md
# Scoreboard Dynamic Instruction Scheduler

This block is the central scheduling controller of an out-of-order execution core without register renaming. It accepts one decoded instruction per cycle: a class, a destination register and two source registers. It tells the front end whether the instruction was taken. It tracks every functional unit in a status entry and every architectural register in a table that names the unit due to write it. It launches operand reads and execution when data is available, and it grants the single register-file write port to completed units.

Instructions leave in program order but can start and finish out of order. Structural and write-after-write hazards hold the instruction at the input and block every instruction behind it. Read-after-write hazards hold a unit's operand read. Write-after-read hazards hold a finished unit's write-back. There is no forwarding. The arithmetic is replaced by non-pipelined fixed-latency placeholders, so the block shows only the control timing.

Top module: `sb_sched`

## Requirements
- R1: An instruction is accepted (`in_ready`=1 with `in_valid`=1 at a clock edge) only if a unit of its class is idle. While none is idle, `in_ready` stays 0 and the held instruction blocks all later ones. It is accepted at the edge after the write-back that frees a suitable unit.
- R2: An instruction whose destination register is still pending a write by an active unit is not accepted (`in_ready`=0) until that write happens.
- R3: A dependent instruction is accepted without waiting on its sources. Its operand read (a one-cycle pulse on its unit's `fu_start` bit) comes one cycle after the producer's `wb_en` pulse, and its `wb_en` comes 4 cycles after the producer's for an add-class consumer.
- R4: A finished unit does not write back while another unit that has not yet read its operands still holds the old value of the same register as a ready source. Its `wb_en` comes one cycle after that reader's `fu_start` pulse.
- R5: Unit latencies are 1 cycle for integer, 10 for multiply, 2 for add and 40 for divide. With no hazards, `wb_en` for an instruction is seen latency+2 cycles after the edge that accepted it.
- R6: Class codes and unit identifiers are as follows. Class 0 (integer) goes to unit 1. Class 1 (multiply) goes to unit 2 if it is idle and to unit 3 otherwise. Class 2 (add) goes to unit 4 and class 3 (divide) to unit 5. `wb_unit` reports the unit identifier, and `fu_start` bit i belongs to unit i+1. The identifier 0 means no producer.
- R7: When several units may write back in the same cycle, the lowest unit identifier wins. The others write in following cycles.
- R8: When a write-back clears a register's pending entry in the same cycle that an instruction arrives, the instruction sees the cleared entry. An instruction blocked only by a write-after-write hazard is accepted at the edge of that write-back.
- R9: Synchronous active-high reset makes all units idle and clears the register table. After reset an instruction of any class is accepted at once, and nothing that was in flight produces a `wb_en`.
- R10: `wb_reg` carries the destination register of the instruction that is writing back.
- R11: Each accepted instruction produces exactly one single-cycle pulse on its unit's `fu_start` bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Decoded instruction present |
| in_cls | input | 2 | Operation class: 0 integer, 1 multiply, 2 add, 3 divide |
| in_dst | input | 5 | Destination register |
| in_src1 | input | 5 | First source register |
| in_src2 | input | 5 | Second source register |
| in_ready | output | 1 | Instruction accepted at this edge when valid |
| fu_start | output | 5 | Per-unit operand read and execute pulse (bit i = unit i+1) |
| wb_en | output | 1 | Register-file write port granted |
| wb_reg | output | 5 | Register being written |
| wb_unit | output | 3 | Unit identifier that is writing |

## Verification
On every cycle the assertions check the following. Acceptance happens only into an idle unit and never onto a register with a pending write. Each busy entry holds the class its unit serves. The write-port grant is one-hot and within the requests. Start pulses last one cycle and never hit a unit that is still counting. The exact cycle relations between events can be shown only by the bench scenarios: latency per class, the read one cycle after the producer's write, the write-after-read hold released by the reader's start, the priority order on a shared completion cycle, and acceptance on the freeing edge.

// File: rtl/sb_pkg.sv
`timescale 1ns/1ps
package sb_pkg;
  localparam int NREG  = 32;
  localparam int REG_W = $clog2(NREG);
  localparam int NU    = 5;
  localparam int FU_W  = $clog2(NU + 1);

  localparam logic [1:0] CLS_INT = 2'd0;
  localparam logic [1:0] CLS_MUL = 2'd1;
  localparam logic [1:0] CLS_ADD = 2'd2;
  localparam logic [1:0] CLS_DIV = 2'd3;

  // class served by each unit slot (slot i has identifier i+1)
  localparam logic [1:0] UNIT_CLS [NU] = '{CLS_INT, CLS_MUL, CLS_MUL, CLS_ADD, CLS_DIV};

  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_RD = 2'd1, ST_EX = 2'd2, ST_DN = 2'd3} st_e;

  typedef struct packed {
    st_e              st;
    logic [1:0]       op;
    logic [REG_W-1:0] fi;
    logic [REG_W-1:0] fj;
    logic [REG_W-1:0] fk;
    logic [FU_W-1:0]  qj;
    logic [FU_W-1:0]  qk;
    logic             rj;
    logic             rk;
  } fu_ent_t;
endpackage

// File: rtl/sb_fu_stub.sv
`timescale 1ns/1ps
module sb_fu_stub #(
  parameter int LAT = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic done
);
  localparam int CW = $clog2(LAT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (start)        cnt <= CW'(LAT);
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign done = (cnt == CW'(1));

  // R11: a non-pipelined unit is never restarted while counting
  p_no_restart_r11: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) |-> !start);
endmodule

// File: rtl/sb_wb_arb.sv
`timescale 1ns/1ps
module sb_wb_arb #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  always_comb begin
    gnt = '0;
    for (int i = 0; i < N; i++)
      if (req[i] && gnt == '0) gnt[i] = 1'b1;
  end

  // R7: one writer at most, and only a requester
  p_gnt_onehot_r7: assert property (@(posedge clk) disable iff (rst) $onehot0(gnt));
  p_gnt_in_req_r7: assert property (@(posedge clk) disable iff (rst) (gnt & ~req) == '0);
endmodule

// File: rtl/sb_issue_sel.sv
`timescale 1ns/1ps
module sb_issue_sel
  import sb_pkg::*;
(
  input  logic [NU-1:0]   busy,
  input  logic [1:0]      cls,
  output logic [FU_W-1:0] tgt,
  output logic            free
);
  always_comb begin
    tgt  = '0;
    free = 1'b0;
    case (cls)
      CLS_INT: begin tgt = FU_W'(0); free = !busy[0]; end
      CLS_MUL: begin
        tgt  = busy[1] ? FU_W'(2) : FU_W'(1);
        free = !busy[1] || !busy[2];
      end
      CLS_ADD: begin tgt = FU_W'(3); free = !busy[3]; end
      default: begin tgt = FU_W'(4); free = !busy[4]; end
    endcase
  end
endmodule

// File: rtl/sb_sched.sv
`timescale 1ns/1ps
module sb_sched
  import sb_pkg::*;
#(
  parameter int LAT_INT = 1,
  parameter int LAT_MUL = 10,
  parameter int LAT_ADD = 2,
  parameter int LAT_DIV = 40
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [1:0]       in_cls,
  input  logic [REG_W-1:0] in_dst,
  input  logic [REG_W-1:0] in_src1,
  input  logic [REG_W-1:0] in_src2,
  output logic             in_ready,
  output logic [NU-1:0]    fu_start,
  output logic             wb_en,
  output logic [REG_W-1:0] wb_reg,
  output logic [FU_W-1:0]  wb_unit
);
  localparam int LATS [NU] = '{LAT_INT, LAT_MUL, LAT_MUL, LAT_ADD, LAT_DIV};

  fu_ent_t          ent [NU];
  logic [FU_W-1:0]  rrt [NREG];
  logic [NU-1:0]    busy, done, rd_fire, war_ok, wb_req, wb_gnt;
  logic [FU_W-1:0]  tgt, wb_idx, wb_id;
  logic [FU_W-1:0]  q1, q2, qd;
  logic [REG_W-1:0] wb_fi;
  logic             unit_free, have_wb, issue;

  always_comb
    for (int u = 0; u < NU; u++) busy[u] = (ent[u].st != ST_IDLE);

  sb_issue_sel u_sel (.busy(busy), .cls(in_cls), .tgt(tgt), .free(unit_free));

  // write-back selection
  always_comb begin
    for (int u = 0; u < NU; u++) begin
      war_ok[u] = 1'b1;
      for (int f = 0; f < NU; f++)
        if (f != u && ent[f].st == ST_RD &&
            ((ent[f].rj && ent[f].fj == ent[u].fi) ||
             (ent[f].rk && ent[f].fk == ent[u].fi)))
          war_ok[u] = 1'b0;
      wb_req[u]  = (ent[u].st == ST_DN) && war_ok[u];
      rd_fire[u] = (ent[u].st == ST_RD) && ent[u].rj && ent[u].rk;
    end
  end

  sb_wb_arb #(.N(NU)) u_arb (.clk(clk), .rst(rst), .req(wb_req), .gnt(wb_gnt));

  always_comb begin
    wb_idx = '0;
    for (int i = NU - 1; i >= 0; i--)
      if (wb_gnt[i]) wb_idx = FU_W'(i);
  end

  assign have_wb = |wb_gnt;
  assign wb_id   = wb_idx + 1'b1;
  assign wb_fi   = ent[wb_idx].fi;

  // register table as seen this cycle, with the current write already cleared
  always_comb begin
    q1 = (have_wb && in_src1 == wb_fi) ? '0 : rrt[in_src1];
    q2 = (have_wb && in_src2 == wb_fi) ? '0 : rrt[in_src2];
    qd = (have_wb && in_dst  == wb_fi) ? '0 : rrt[in_dst];
  end

  assign in_ready = unit_free && (qd == '0);
  assign issue    = in_valid && in_ready;

  // unit status entries
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int u = 0; u < NU; u++) ent[u] <= '0;
    end else begin
      for (int u = 0; u < NU; u++) begin
        if (issue && int'(tgt) == u) begin
          ent[u].st <= ST_RD;
          ent[u].op <= in_cls;
          ent[u].fi <= in_dst;
          ent[u].fj <= in_src1;
          ent[u].fk <= in_src2;
          ent[u].qj <= q1;
          ent[u].qk <= q2;
          ent[u].rj <= (q1 == '0);
          ent[u].rk <= (q2 == '0);
        end else begin
          case (ent[u].st)
            ST_RD: begin
              if (rd_fire[u]) begin
                ent[u].st <= ST_EX;
                ent[u].rj <= 1'b0;
                ent[u].rk <= 1'b0;
                ent[u].qj <= '0;
                ent[u].qk <= '0;
              end else begin
                if (have_wb && ent[u].qj == wb_id) begin
                  ent[u].rj <= 1'b1;
                  ent[u].qj <= '0;
                end
                if (have_wb && ent[u].qk == wb_id) begin
                  ent[u].rk <= 1'b1;
                  ent[u].qk <= '0;
                end
              end
            end
            ST_EX:   if (done[u])   ent[u].st <= ST_DN;
            ST_DN:   if (wb_gnt[u]) ent[u].st <= ST_IDLE;
            default: ;
          endcase
        end
      end
    end
  end

  // register result table
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NREG; r++) rrt[r] <= '0;
    end else begin
      if (have_wb) rrt[wb_fi]  <= '0;
      if (issue)   rrt[in_dst] <= tgt + 1'b1;
    end
  end

  // registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      fu_start <= '0;
      wb_en    <= 1'b0;
      wb_reg   <= '0;
      wb_unit  <= '0;
    end else begin
      fu_start <= rd_fire;
      wb_en    <= have_wb;
      wb_reg   <= wb_fi;
      wb_unit  <= have_wb ? wb_id : '0;
    end
  end

  for (genvar g = 0; g < NU; g++) begin : g_fu
    sb_fu_stub #(.LAT(LATS[g])) u_fu (
      .clk(clk), .rst(rst), .start(rd_fire[g]), .done(done[g]));

    // R11: start is a single-cycle pulse
    p_start_pulse_r11: assert property (@(posedge clk) disable iff (rst)
      fu_start[g] |=> !fu_start[g]);
    // R6: a busy entry always holds the class its unit serves
    p_unit_cls_r6: assert property (@(posedge clk) disable iff (rst)
      (ent[g].st != ST_IDLE) |-> (ent[g].op == UNIT_CLS[g]));
  end

  // R1: acceptance only into an idle unit
  p_issue_free_r1: assert property (@(posedge clk) disable iff (rst)
    issue |-> (ent[tgt].st == ST_IDLE));
  // R2: never accept onto a register with a pending write that is not being retired now
  p_issue_nowaw_r2: assert property (@(posedge clk) disable iff (rst)
    issue |-> (rrt[in_dst] == '0 || (have_wb && wb_fi == in_dst)));
endmodule

// File: tb/sb_sched_tb_top.sv
`timescale 1ns/1ps
module sb_sched_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [1:0] in_cls = '0;
  logic [4:0] in_dst = '0, in_src1 = '0, in_src2 = '0;
  logic       in_ready;
  logic [4:0] fu_start;
  logic       wb_en;
  logic [4:0] wb_reg;
  logic [2:0] wb_unit;

  sb_sched dut_i (.clk(clk), .rst(rst), .in_valid(in_valid), .in_cls(in_cls),
    .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2), .in_ready(in_ready),
    .fu_start(fu_start), .wb_en(wb_en), .wb_reg(wb_reg), .wb_unit(wb_unit));

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_bad = 0;
  int wb_cnt [6], wb_c [6], wb_r [6], st_cnt [6], st_c [6];

  initial for (int i = 0; i < 6; i++) begin
    wb_cnt[i] = 0; wb_c[i] = 0; wb_r[i] = 0; st_cnt[i] = 0; st_c[i] = 0;
  end

  always @(negedge clk) begin
    if (wb_en && wb_unit >= 1 && wb_unit <= 5) begin
      wb_cnt[wb_unit] = wb_cnt[wb_unit] + 1;
      wb_c[wb_unit]   = cyc;
      wb_r[wb_unit]   = int'(wb_reg);
    end
    for (int u = 0; u < 5; u++)
      if (fu_start[u]) begin
        st_cnt[u+1] = st_cnt[u+1] + 1;
        st_c[u+1]   = cyc;
      end
  end

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  // called at negedge+1; returns the edge number that accepted the instruction
  task automatic send(input int cls, input int dst, input int s1, input int s2, output int ic);
    in_cls = 2'(cls); in_dst = 5'(dst); in_src1 = 5'(s1); in_src2 = 5'(s2);
    in_valid = 1'b1;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    ic = cyc + 1;
    @(negedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic wait_wb(input int u, input int n, output int c, output int r);
    while (wb_cnt[u] < n) begin @(negedge clk); #1; end
    c = wb_c[u]; r = wb_r[u];
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  localparam int NV = 6;
  localparam int V_CLS [NV] = '{0, 1, 2, 3, 0, 2};
  localparam int V_DST [NV] = '{1, 2, 3, 4, 5, 31};
  localparam int V_S1  [NV] = '{0, 1, 2, 3, 4, 0};
  localparam int V_S2  [NV] = '{0, 1, 2, 3, 4, 31};
  localparam int V_UID [NV] = '{1, 2, 4, 5, 1, 4};
  localparam int V_DLY [NV] = '{3, 12, 4, 42, 3, 4};

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int ia, ib, ic, wa, wb, wc, r, s, s2, s4, s5;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(1);

    // R9: state after reset
    in_cls = 2'd0; in_dst = 5'd1;
    #0;
    chk("R9 ready after reset", int'(in_ready), 1);
    chk("R9 no wb after reset", int'(wb_en), 0);
    chk("R9 no start after reset", int'(fu_start), 0);

    // R5 R6 R10 R11: isolated instructions from the vector table
    for (int i = 0; i < NV; i++) begin
      s = wb_cnt[V_UID[i]];
      s2 = st_cnt[V_UID[i]];
      send(V_CLS[i], V_DST[i], V_S1[i], V_S2[i], ia);
      wait_wb(V_UID[i], s + 1, wa, r);
      chk("R5 latency to wb", wa - ia, V_DLY[i]);
      chk("R10 wb register", r, V_DST[i]);
      chk("R6 wb unit count", wb_cnt[V_UID[i]] - s, 1);
      chk("R11 one start", st_cnt[V_UID[i]] - s2, 1);
      idle(2);
    end

    // R3: read after write, no forwarding
    s2 = wb_cnt[2]; s4 = wb_cnt[4];
    send(1, 5, 0, 0, ia);
    send(2, 6, 5, 0, ib);
    chk("R3 dependent accepted at once", ib - ia, 1);
    wait_wb(2, s2 + 1, wa, r);
    wait_wb(4, s4 + 1, wb, r);
    chk("R3 read after producer wb", st_c[4] - wa, 1);
    chk("R3 consumer wb spacing", wb - wa, 4);
    idle(2);

    // R2 R8: write after write stall, accepted on the retiring edge
    s2 = wb_cnt[2]; s = wb_cnt[1];
    send(1, 7, 0, 0, ia);
    in_cls = 2'd0; in_dst = 5'd7; in_src1 = 5'd0; in_src2 = 5'd0; in_valid = 1'b1;
    #1;
    chk("R2 waw stall", int'(in_ready), 0);
    send(0, 7, 0, 0, ib);
    wait_wb(2, s2 + 1, wa, r);
    chk("R8 accept on wb edge", ib, wa);
    wait_wb(1, s + 1, wb, r);
    idle(2);

    // R1 R6: structural stall on both multipliers
    s2 = wb_cnt[2]; s = wb_cnt[3];
    send(1, 13, 0, 0, ia);
    send(1, 14, 0, 0, ib);
    chk("R1 second mult accepted", ib - ia, 1);
    in_cls = 2'd1; in_dst = 5'd15; in_valid = 1'b1;
    #1;
    chk("R1 structural stall", int'(in_ready), 0);
    send(1, 15, 0, 0, ic);
    wait_wb(2, s2 + 1, wa, r);
    chk("R1 accept after unit frees", ic - wa, 1);
    wait_wb(3, s + 1, wb, r);
    chk("R6 second mult unit3 reg", r, 14);
    wait_wb(2, s2 + 2, wc, r);
    chk("R6 third mult on unit2", r, 15);
    idle(2);

    // R4: write after read hold
    s5 = wb_cnt[5]; s4 = wb_cnt[4]; s2 = wb_cnt[2];
    send(3, 10, 0, 0, ia);
    send(1, 11, 10, 12, ib);
    send(2, 12, 1, 1, ic);
    wait_wb(4, s4 + 1, wb, r);
    wait_wb(5, s5 + 1, wa, r);
    chk("R4 wb after reader start", wb - st_c[2], 1);
    chk("R4 wb held past divide", wb - wa, 2);
    wait_wb(2, s2 + 1, wc, r);
    idle(2);

    // R7: same-cycle completion, lowest identifier first
    s4 = wb_cnt[4]; s = wb_cnt[1];
    send(2, 20, 0, 0, ia);
    send(0, 21, 0, 0, ib);
    wait_wb(4, s4 + 1, wb, r);
    wait_wb(1, s + 1, wa, r);
    chk("R7 integer wins", wa - ia, 4);
    chk("R7 adder next cycle", wb - ia, 5);
    idle(2);

    // R9: reset while a divide is in flight
    s5 = wb_cnt[5];
    send(3, 25, 0, 0, ia);
    idle(2);
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    in_cls = 2'd3; in_dst = 5'd25; in_valid = 1'b0;
    #1;
    chk("R9 ready after mid reset", int'(in_ready), 1);
    idle(50);
    chk("R9 flushed divide silent", wb_cnt[5] - s5, 0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule